// File: doc/BRIEF.md
# Segmented Carry-Select Adder

This block produces the final carry-propagate sum of two wide vectors, typically the redundant sum and carry words left by a multiplier's partial-product tree. When an accumulate value has already been folded into that tree, this sum is the multiply-accumulate result. The default operand width is 64 bits, and the adder is split into four 16-bit slices.

The lowest slice is added once, with a carry-in of zero. Every higher slice is added twice, once assuming a carry-in of 0 and once assuming 1, so there are seven slice adders in all. A multiplexer keeps one copy of each higher slice. Its select is the carry-out of the copy already chosen for the slice below, so the only serial path between slices is one mux per slice.

Inside each slice there are two lookahead levels. Four-bit groups produce their bit carries plus a group generate and a group propagate. A second lookahead network combines those group signals into the carry into each group and the slice carry-out. The carry out of the top bit is dropped. The sum is registered once, with a synchronous active-high reset.

Top module: `csel_segment_adder`

## Requirements
- R1: One rising clock edge after operands `a` and `b` are applied (reset low), `sum` equals (a + b) mod 2^64.
- R2: While `rst` is high at a rising edge, `sum` becomes zero whatever the operands are.
- R3: The carry out of bit 63 is discarded, so all-ones plus one gives zero and 0x8000_0000_0000_0000 + 0x8000_0000_0000_0000 gives zero.
- R4: Bits 15:0 of `sum` equal the 16-bit sum of a[15:0] and b[15:0] with carry-in 0, independent of the upper operand bits.
- R5: The carry used to select the slices at bits 16, 32 and 48 equals the true carry out of all bits below that boundary. For example, 0x0000_0000_0000_FFFF + 1 gives 0x0000_0000_0001_0000.
- R6: A carry ripples across several slice boundaries in one pass. For example, 0x0000_FFFF_FFFF_FFFF + 1 gives 0x0001_0000_0000_0000.
- R7: Carries cross 4-bit group boundaries inside a slice. For example, 0x0F + 1 gives 0x10 and 0x0FFF + 1 gives 0x1000.
- R8: The result does not depend on operand order: a + b and b + a give the same `sum`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; `sum` updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset that clears `sum` |
| a | input | 64 | First operand (sum word from the tree) |
| b | input | 64 | Second operand (carry word from the tree) |
| sum | output | 64 | Registered (a + b) mod 2^64 |

## Verification
Random 64-bit operand pairs check the general sum. They cannot show whether a particular boundary carry is correct, because long propagate runs are rare in random data. Directed carry chains fill that gap:
- one-plus-all-ones inside a single 4-bit group, across group edges, across each 16-bit slice edge, and through all slices up to wrap-around;
- alternating 0x5555/0xAAAA patterns, which propagate at every bit without generating, so a single injected carry must travel the whole width;
- values that generate right at a slice boundary, which separate a wrong mux select from a wrong slice copy.

Low-slice tests hold a[15:0] and b[15:0] fixed while changing the upper bits. Swapped operand pairs and a reset applied during live traffic complete the set.

// File: rtl/csel_add_pkg.sv
package csel_add_pkg;
  parameter int unsigned DEF_DATA_W = 64;
  parameter int unsigned DEF_SEG_W  = 16;
  parameter int unsigned DEF_GRP_W  = 4;
endpackage

// File: rtl/la_net.sv
// Generic lookahead network: carry into every position, plus block generate/propagate.
module la_net #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] g,
  input  logic [N-1:0] p,
  input  logic         cin,
  output logic [N-1:0] c,
  output logic         blk_g,
  output logic         blk_p
);
  always_comb begin
    logic term;
    logic acc;
    for (int i = 0; i < N; i++) begin
      // sum of products: cin propagated, or generate at j propagated to i
      acc = cin;
      for (int k = 0; k < i; k++) acc = acc & p[k];
      for (int j = 0; j < i; j++) begin
        term = g[j];
        for (int k = j + 1; k < i; k++) term = term & p[k];
        acc = acc | term;
      end
      c[i] = acc;
    end
    blk_g = 1'b0;
    for (int j = 0; j < N; j++) begin
      term = g[j];
      for (int k = j + 1; k < N; k++) term = term & p[k];
      blk_g = blk_g | term;
    end
    blk_p = &p;
  end
endmodule

// File: rtl/cla_group.sv
// One lookahead group: local sum plus group generate/propagate.
module cla_group #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         gg,
  output logic         gp
);
  logic [W-1:0] bit_g;
  logic [W-1:0] bit_p;
  logic [W-1:0] bit_c;

  assign bit_g = a & b;
  assign bit_p = a ^ b;

  la_net #(.N(W)) u_la (
    .g     (bit_g),
    .p     (bit_p),
    .cin   (cin),
    .c     (bit_c),
    .blk_g (gg),
    .blk_p (gp)
  );

  assign s = bit_p ^ bit_c;
endmodule

// File: rtl/seg_add.sv
// One slice: groups of lookahead adders tied by a second lookahead level.
module seg_add #(
  parameter int unsigned SEG_W = 16,
  parameter int unsigned GRP_W = 4
) (
  input  logic [SEG_W-1:0] a,
  input  logic [SEG_W-1:0] b,
  input  logic             cin,
  output logic [SEG_W-1:0] s,
  output logic             cout
);
  localparam int unsigned NGRP = SEG_W / GRP_W;

  logic [NGRP-1:0] grp_g;
  logic [NGRP-1:0] grp_p;
  logic [NGRP-1:0] grp_c;
  logic            seg_g;
  logic            seg_p;

  la_net #(.N(NGRP)) u_la2 (
    .g     (grp_g),
    .p     (grp_p),
    .cin   (cin),
    .c     (grp_c),
    .blk_g (seg_g),
    .blk_p (seg_p)
  );

  for (genvar k = 0; k < NGRP; k++) begin : g_grp
    cla_group #(.W(GRP_W)) u_grp (
      .a   (a[k*GRP_W +: GRP_W]),
      .b   (b[k*GRP_W +: GRP_W]),
      .cin (grp_c[k]),
      .s   (s[k*GRP_W +: GRP_W]),
      .gg  (grp_g[k]),
      .gp  (grp_p[k])
    );
  end

  assign cout = seg_g | (seg_p & cin);
endmodule

// File: rtl/csel_segment_adder.sv
module csel_segment_adder
  import csel_add_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned SEG_W  = DEF_SEG_W,
  parameter int unsigned GRP_W  = DEF_GRP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] sum
);
  localparam int unsigned NSEG = DATA_W / SEG_W;

  logic [NSEG-1:0]   seg_cin;   // selected carry into each slice
  logic [NSEG-1:0]   seg_cout;  // selected carry out of each slice
  logic [DATA_W-1:0] sum_c;
  logic [DATA_W-1:0] sum_q;

  assign seg_cin[0] = 1'b0;

  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    if (k == 0) begin : g_base
      seg_add #(.SEG_W(SEG_W), .GRP_W(GRP_W)) u_base (
        .a    (a[SEG_W-1:0]),
        .b    (b[SEG_W-1:0]),
        .cin  (1'b0),
        .s    (sum_c[SEG_W-1:0]),
        .cout (seg_cout[0])
      );
    end else begin : g_dual
      logic [SEG_W-1:0] s_c0;
      logic [SEG_W-1:0] s_c1;
      logic             co_c0;
      logic             co_c1;

      seg_add #(.SEG_W(SEG_W), .GRP_W(GRP_W)) u_c0 (
        .a    (a[k*SEG_W +: SEG_W]),
        .b    (b[k*SEG_W +: SEG_W]),
        .cin  (1'b0),
        .s    (s_c0),
        .cout (co_c0)
      );
      seg_add #(.SEG_W(SEG_W), .GRP_W(GRP_W)) u_c1 (
        .a    (a[k*SEG_W +: SEG_W]),
        .b    (b[k*SEG_W +: SEG_W]),
        .cin  (1'b1),
        .s    (s_c1),
        .cout (co_c1)
      );

      assign seg_cin[k]               = seg_cout[k-1];
      assign sum_c[k*SEG_W +: SEG_W]  = seg_cin[k] ? s_c1 : s_c0;
      assign seg_cout[k]              = seg_cin[k] ? co_c1 : co_c0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sum_q <= '0;
    else     sum_q <= sum_c;
  end

  assign sum = sum_q;
endmodule

// File: rtl/csel_segment_adder_chk.sv
module csel_segment_adder_chk #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned SEG_W  = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic [DATA_W-1:0]        a,
  input logic [DATA_W-1:0]        b,
  input logic [DATA_W-1:0]        sum,
  input logic [DATA_W/SEG_W-1:0]  seg_cin
);
  localparam int unsigned NSEG = DATA_W / SEG_W;

  logic [DATA_W-1:0] ref_q;
  logic [SEG_W-1:0]  low_ref_q;
  logic              ovf_q;
  logic              live_q;
  logic              was_rst_q;

  always_ff @(posedge clk) begin
    ref_q     <= a + b;
    low_ref_q <= a[SEG_W-1:0] + b[SEG_W-1:0];
    ovf_q     <= ({1'b0, a} + {1'b0, b}) >> DATA_W != '0;
    live_q    <= !rst;
    was_rst_q <= rst;
  end

  // R1: registered sum matches modular reference
  p_sum_match_r1: assert property (@(posedge clk) disable iff (rst)
    live_q |-> sum == ref_q);

  // R2: cycle after a reset edge the output is zero
  p_reset_clear_r2: assert property (@(posedge clk) disable iff (rst)
    was_rst_q |-> sum == '0);

  // R3: on overflow the kept result is below the first operand
  p_wrap_drop_r3: assert property (@(posedge clk) disable iff (rst)
    (live_q && ovf_q) |-> sum < $past(a));

  // R4: low slice depends only on low operand bits
  p_low_slice_r4: assert property (@(posedge clk) disable iff (rst)
    live_q |-> sum[SEG_W-1:0] == low_ref_q);

  // R5: every slice select equals the true carry across that boundary
  for (genvar k = 1; k < NSEG; k++) begin : g_sel
    localparam int unsigned LW = k * SEG_W;
    logic [LW:0] part;
    assign part = {1'b0, a[LW-1:0]} + {1'b0, b[LW-1:0]};
    p_seg_select_r5: assert property (@(posedge clk) disable iff (rst)
      seg_cin[k] == part[LW]);
  end
endmodule

bind csel_segment_adder csel_segment_adder_chk #(
  .DATA_W (DATA_W),
  .SEG_W  (SEG_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .a       (a),
  .b       (b),
  .sum     (sum),
  .seg_cin (seg_cin)
);

// File: tb/tb_csel_segment_adder.sv
`timescale 1ns/1ps
module tb_csel_segment_adder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] a = '0;
  logic [63:0] b = '0;
  logic [63:0] sum;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  csel_segment_adder dut (
    .clk (clk),
    .rst (rst),
    .a   (a),
    .b   (b),
    .sum (sum)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // driver: applies operands and pushes the expected result
  task automatic drive(input logic [63:0] x, input logic [63:0] y, input string tag);
    @(negedge clk);
    a = x;
    b = y;
    exp_q.push_back(x + y);
    tag_q.push_back(tag);
  endtask

  // monitor: compares after each capture edge
  always begin
    @(posedge clk);
    #1;
    if (exp_q.size() > 0) begin
      logic [63:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, sum, e);
    end
  end

  task automatic drain();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [63:0] x;
    logic [63:0] y;
    a = 64'hDEAD_BEEF_0123_4567;
    b = 64'h1111_2222_3333_4444;
    repeat (2) @(posedge clk);
    #1;
    check("R2 reset state", sum, 64'h0);
    @(negedge clk);
    rst = 1'b0;

    // R7: carries across 4-bit group edges
    drive(64'h0F, 64'h1, "R7 group edge 4");
    drive(64'h0FF, 64'h1, "R7 group edge 8");
    drive(64'h0FFF, 64'h1, "R7 group edge 12");
    // R5: carry selects at each slice edge
    drive(64'h0000_0000_0000_FFFF, 64'h1, "R5 edge 16");
    drive(64'h0000_0000_FFFF_0000, 64'h0001_0000, "R5 edge 32");
    drive(64'h0000_FFFF_0000_0000, 64'h0000_0001_0000_0000, "R5 edge 48");
    drive(64'h0000_8000_0000_8000, 64'h0000_8000_0000_8000, "R5 generate at edges");
    // R6: multi-slice ripple
    drive(64'h0000_FFFF_FFFF_FFFF, 64'h1, "R6 ripple to 48");
    drive(64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAB, "R6 alternating chain");
    drive(64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, "R6 alternating no carry");
    // R3: wrap-around
    drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, "R3 all ones plus one");
    drive(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, "R3 top bits");
    drive(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R3 max plus max");
    // R4: low slice independent of upper bits
    for (int i = 0; i < 8; i++) begin
      x = {$urandom, $urandom};
      y = {$urandom, $urandom};
      x[15:0] = 16'hF00F;
      y[15:0] = 16'h1FF3;
      drive(x, y, "R4 low slice fixed");
    end
    // R8: operand swap
    for (int i = 0; i < 16; i++) begin
      x = {$urandom, $urandom};
      y = {$urandom, $urandom};
      drive(x, y, "R8 order ab");
      drive(y, x, "R8 order ba");
    end
    // R1: random operands
    for (int i = 0; i < 400; i++) begin
      x = {$urandom, $urandom};
      y = {$urandom, $urandom};
      drive(x, y, "R1 random");
    end
    drain();

    // R2: reset during live operands
    @(negedge clk);
    a = 64'hFFFF_FFFF_FFFF_FFFF;
    b = 64'h1234;
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R2 reset mid-run", sum, 64'h0);
    @(negedge clk);
    rst = 1'b0;
    drive(64'h7, 64'h9, "R1 after reset");
    drain();

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule